// File: doc/BRIEF.md
# Ping-Pong FIFO Fill Engine

This block moves a finished region of a large word-addressed staging RAM into one of two output FIFOs that are used in alternation. Each FIFO channel has its own request line and its own completion line. When the upstream manager raises the request for a channel, the engine reads that channel's half of the staging RAM. It reads from the lowest address upward and pushes every word into that channel's FIFO. It honours the RAM's one-cycle read latency and stalls whenever the FIFO is not ready.

The engine does not decide which half is complete or when data arrives. It only copies the data, in address order. Completion is reported with a four-phase handshake. The completion line rises after the last word has been accepted. It stays high while the request is held and drops one cycle after the request is removed. Only then can the engine take new work. When both requests are raised together, the lower channel is served first.

Top module: `ppf_fill_engine`

## Requirements
- R1: While reset is high, and in the first cycle after it, every completion line, every FIFO write-valid line and the RAM read-enable are low.
- R2: Channel c copies staging addresses c*WORDS to c*WORDS+WORDS-1 (default WORDS=4096, 13-bit RAM address) to FIFO port c. Each word is written exactly once, in ascending address order, and carries the RAM content of that address.
- R3: A word is transferred only in a cycle where write-valid and ready are both high. While ready is low, write-valid and write-data of that channel hold their values.
- R4: At most one FIFO write-valid line is high in any cycle, and only the channel being filled asserts it.
- R5: The completion line of a channel rises on the clock edge that accepts the channel's last word, and never earlier.
- R6: The completion line stays high for as long as that channel's request stays high.
- R7: The completion line drops on the first clock edge at which the channel's request is seen low.
- R8: When both requests are high together, channel 0 is filled first. Channel 1 writes nothing until channel 0's handshake has completed.
- R9: A request that is dropped after a fill has started does not abort the fill. The whole block is copied and completion is still raised, for one cycle if the request stays low.
- R10: No RAM read and no FIFO write is issued while the engine is idle or is holding a completion line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| fill_en_i | input | NUM_CH | Per-channel fill request |
| fill_done_o | output | NUM_CH | Per-channel fill completion |
| ram_re_o | output | 1 | Staging RAM read enable |
| ram_addr_o | output | ADDR_W | Staging RAM read address |
| ram_rdata_i | input | DATA_W | Staging RAM read data, one cycle after the read |
| fifo_wvalid_o | output | NUM_CH | Per-channel FIFO write valid |
| fifo_wdata_o | output | NUM_CH*DATA_W | Per-channel FIFO write data, channel c in slice c |
| fifo_wready_i | input | NUM_CH | Per-channel FIFO ready (not full) |

## Verification
If the read counter and the write counter disagree, or the skid buffer loses track of the RAM latency, the effect shows at the FIFO port as a duplicated, dropped or shifted word. The per-address data check catches this on the very first word affected. A wrong word count in the control state moves the rise of the completion line away from the edge that accepts the last word, so the cycle-exact completion check exposes it within one cycle. If arbitration or the handshake state is wrong, channel 1 writes while channel 0's request or completion is still high, or the completion line fails to drop one edge after its request falls. Both of these show up in the first cycle they occur.

// File: rtl/ppf_pkg.sv
package ppf_pkg;

    typedef enum logic [1:0] {
        PPF_IDLE = 2'd0,
        PPF_BUSY = 2'd1,
        PPF_HOLD = 2'd2
    } ppf_state_e;

    // index of the lowest set bit of an (up to) 8-wide request vector
    function automatic logic [2:0] ppf_lowest(input logic [7:0] req);
        logic [2:0] sel;
        sel = 3'd0;
        for (int i = 7; i >= 0; i--) begin
            if (req[i]) sel = 3'(i);
        end
        return sel;
    endfunction

endpackage

// File: rtl/ppf_rd_seq.sv
module ppf_rd_seq #(
    parameter int unsigned ADDR_W = 13,
    parameter int unsigned CNT_W  = 13,
    parameter int unsigned WORDS  = 4096
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              start_i,
    input  logic              allow_i,
    input  logic [ADDR_W-1:0] base_i,
    output logic              re_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              rvld_o
);
    logic [CNT_W-1:0] issued_q;
    logic             all_issued;

    assign all_issued = (issued_q == CNT_W'(WORDS));
    assign re_o       = allow_i && !all_issued;
    assign addr_o     = base_i + ADDR_W'(issued_q);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            issued_q <= CNT_W'(WORDS);
            rvld_o   <= 1'b0;
        end else begin
            rvld_o <= re_o;
            if (start_i)   issued_q <= '0;
            else if (re_o) issued_q <= issued_q + 1'b1;
        end
    end
endmodule

// File: rtl/ppf_skid.sv
module ppf_skid #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 2,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              pop_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o,
    output logic [LVL_W-1:0]  level_o
);
    logic [DATA_W-1:0] slot_q [DEPTH];
    logic [PTR_W-1:0]  wptr_q, rptr_q;

    assign valid_o = (level_o != '0);
    assign data_o  = slot_q[rptr_q];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            wptr_q  <= '0;
            rptr_q  <= '0;
            level_o <= '0;
        end else begin
            if (push_i) begin
                slot_q[wptr_q] <= push_data_i;
                wptr_q         <= bump(wptr_q);
            end
            if (pop_i) rptr_q <= bump(rptr_q);
            case ({push_i, pop_i})
                2'b10:   level_o <= level_o + 1'b1;
                2'b01:   level_o <= level_o - 1'b1;
                default: level_o <= level_o;
            endcase
        end
    end
endmodule

// File: rtl/ppf_ctrl.sv
module ppf_ctrl
    import ppf_pkg::*;
#(
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned WORDS  = 4096,
    parameter int unsigned ADDR_W = 13,
    parameter int unsigned CNT_W  = 13,
    localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [NUM_CH-1:0] en_i,
    input  logic              pop_i,
    output logic              start_o,
    output logic              busy_o,
    output logic [CH_W-1:0]   ch_o,
    output logic [ADDR_W-1:0] base_o,
    output logic [NUM_CH-1:0] done_o
);
    ppf_state_e       state_q;
    logic [CNT_W-1:0] written_q;
    logic [2:0]       pick;

    assign pick    = ppf_lowest(8'(en_i));
    assign start_o = (state_q == PPF_IDLE) && (|en_i);
    assign busy_o  = (state_q == PPF_BUSY);
    assign base_o  = ADDR_W'(ch_o) * ADDR_W'(WORDS);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_done
        assign done_o[c] = (state_q == PPF_HOLD) && (ch_o == CH_W'(c));
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q   <= PPF_IDLE;
            ch_o      <= '0;
            written_q <= '0;
        end else begin
            case (state_q)
                PPF_IDLE: if (start_o) begin
                    ch_o      <= CH_W'(pick);
                    written_q <= '0;
                    state_q   <= PPF_BUSY;
                end
                PPF_BUSY: if (pop_i) begin
                    written_q <= written_q + 1'b1;
                    if (written_q == CNT_W'(WORDS - 1)) state_q <= PPF_HOLD;
                end
                PPF_HOLD: if (!en_i[ch_o]) state_q <= PPF_IDLE;
                default: state_q <= PPF_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ppf_fill_engine.sv
module ppf_fill_engine #(
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned WORDS  = 4096,
    localparam int unsigned ADDR_W = $clog2(NUM_CH * WORDS),
    localparam int unsigned CNT_W  = $clog2(WORDS + 1),
    localparam int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int unsigned SKID_D = 2,
    localparam int unsigned LVL_W  = $clog2(SKID_D + 1)
) (
    input  logic                     clk_i,
    input  logic                     rst_i,
    input  logic [NUM_CH-1:0]        fill_en_i,
    output logic [NUM_CH-1:0]        fill_done_o,
    output logic                     ram_re_o,
    output logic [ADDR_W-1:0]        ram_addr_o,
    input  logic [DATA_W-1:0]        ram_rdata_i,
    output logic [NUM_CH-1:0]        fifo_wvalid_o,
    output logic [NUM_CH*DATA_W-1:0] fifo_wdata_o,
    input  logic [NUM_CH-1:0]        fifo_wready_i
);
    logic              start, busy, pend, pop, allow;
    logic [CH_W-1:0]   ch;
    logic [ADDR_W-1:0] base;
    logic              sk_valid;
    logic [DATA_W-1:0] sk_data;
    logic [LVL_W-1:0]  sk_level;

    // issue a read only when the word it returns is sure to find room
    assign pop   = busy && sk_valid && fifo_wready_i[ch];
    assign allow = busy && ((int'(sk_level) + int'(pend)) < (SKID_D + int'(pop)));

    ppf_ctrl #(.NUM_CH(NUM_CH), .WORDS(WORDS), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
        .clk_i (clk_i), .rst_i (rst_i), .en_i (fill_en_i), .pop_i (pop),
        .start_o (start), .busy_o (busy), .ch_o (ch), .base_o (base),
        .done_o (fill_done_o)
    );

    ppf_rd_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .WORDS(WORDS)) u_seq (
        .clk_i (clk_i), .rst_i (rst_i), .start_i (start), .allow_i (allow),
        .base_i (base), .re_o (ram_re_o), .addr_o (ram_addr_o), .rvld_o (pend)
    );

    ppf_skid #(.DATA_W(DATA_W), .DEPTH(SKID_D)) u_skid (
        .clk_i (clk_i), .rst_i (rst_i), .push_i (pend), .push_data_i (ram_rdata_i),
        .pop_i (pop), .valid_o (sk_valid), .data_o (sk_data), .level_o (sk_level)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_port
        logic sel;
        assign sel                              = busy && (ch == CH_W'(c));
        assign fifo_wvalid_o[c]                 = sel && sk_valid;
        assign fifo_wdata_o[c*DATA_W +: DATA_W] = sel ? sk_data : '0;
    end
endmodule

// File: rtl/ppf_fill_engine_chk.sv
module ppf_fill_engine_chk #(
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned DATA_W = 32
) (
    input logic                     clk_i,
    input logic                     rst_i,
    input logic [NUM_CH-1:0]        fill_en_i,
    input logic [NUM_CH-1:0]        fill_done_o,
    input logic                     ram_re_o,
    input logic [NUM_CH-1:0]        fifo_wvalid_o,
    input logic [NUM_CH*DATA_W-1:0] fifo_wdata_o,
    input logic [NUM_CH-1:0]        fifo_wready_i
);
    p_one_writer_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(fifo_wvalid_o));

    p_no_read_in_hold_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (|fill_done_o) |-> !ram_re_o);

    p_no_write_in_hold_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (|fill_done_o) |-> (fifo_wvalid_o == '0));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        p_stall_hold_r3: assert property (@(posedge clk_i) disable iff (rst_i)
            (fifo_wvalid_o[c] && !fifo_wready_i[c]) |=>
            (fifo_wvalid_o[c] && $stable(fifo_wdata_o[c*DATA_W +: DATA_W])));

        p_done_held_r6: assert property (@(posedge clk_i) disable iff (rst_i)
            (fill_done_o[c] && fill_en_i[c]) |=> fill_done_o[c]);

        p_done_release_r7: assert property (@(posedge clk_i) disable iff (rst_i)
            (fill_done_o[c] && !fill_en_i[c]) |=> !fill_done_o[c]);
    end
endmodule

bind ppf_fill_engine ppf_fill_engine_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
    .clk_i (clk_i), .rst_i (rst_i), .fill_en_i (fill_en_i), .fill_done_o (fill_done_o),
    .ram_re_o (ram_re_o), .fifo_wvalid_o (fifo_wvalid_o), .fifo_wdata_o (fifo_wdata_o),
    .fifo_wready_i (fifo_wready_i)
);

// File: tb/ppf_fill_engine_tb.sv
module ppf_fill_engine_tb;
    localparam int unsigned NC = 2;
    localparam int unsigned DW = 32;
    localparam int unsigned W  = 4096;
    localparam int unsigned AW = 13;
    localparam time CLK_PERIOD = 10ns;

    logic            clk = 1'b0;
    logic            rst;
    logic [NC-1:0]   en;
    logic [NC-1:0]   done;
    logic            ram_re;
    logic [AW-1:0]   ram_addr;
    logic [DW-1:0]   ram_rdata;
    logic [NC-1:0]   wvalid;
    logic [NC*DW-1:0] wdata;
    logic [NC-1:0]   wready;

    int checks = 0, fails = 0;
    int cnt [NC];
    logic pend_done [NC];
    logic done_prev [NC];
    int rdy_pct = 100;
    logic r8_watch = 1'b0;
    logic mon_on = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ppf_fill_engine u_dut (
        .clk_i (clk), .rst_i (rst), .fill_en_i (en), .fill_done_o (done),
        .ram_re_o (ram_re), .ram_addr_o (ram_addr), .ram_rdata_i (ram_rdata),
        .fifo_wvalid_o (wvalid), .fifo_wdata_o (wdata), .fifo_wready_i (wready)
    );

    function automatic logic [DW-1:0] stage_word(input int unsigned a);
        return ({a[12:0], 19'h0} ^ (a * 32'h9E3779B1)) + 32'h1357;
    endfunction

    // staging RAM model: one cycle read latency
    always @(posedge clk) if (ram_re) ram_rdata <= stage_word(ram_addr);

    task automatic check(input logic ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic monitor_step();
        for (int c = 0; c < NC; c++) wready[c] = ($urandom_range(99) < rdy_pct);
        check($onehot0(wvalid), "R4 one writer", wvalid, 0);
        if (r8_watch) check(!(wvalid[1] && (en[0] || done[0])), "R8 ch1 waits", wvalid, 0);
        for (int c = 0; c < NC; c++) begin
            if (pend_done[c]) begin
                check(done[c] == 1'b1, "R5 done after last word", done[c], 1);
                pend_done[c] = 1'b0;
            end
            if (done[c] && !done_prev[c]) check(cnt[c] == W, "R5 done only after full block", cnt[c], W);
            if (!done[c] && done_prev[c]) cnt[c] = 0;
            done_prev[c] = done[c];
            if (done[c]) check(!ram_re && wvalid == '0, "R10 quiet in hold", ram_re, 0);
            if (wvalid[c] && wready[c]) begin
                logic [DW-1:0] exp;
                exp = stage_word(c * W + cnt[c]);
                if (wdata[c*DW +: DW] != exp || cnt[c] >= W)
                    check(1'b0, "R2 word order/content", wdata[c*DW +: DW], exp);
                cnt[c]++;
                if (cnt[c] == W) pend_done[c] = 1'b1;
            end
        end
    endtask

    initial forever begin
        @(negedge clk);
        if (mon_on) monitor_step();
    end

    task automatic wait_done(input int c, input string tag);
        int t = 0;
        while (!done[c] && t < 40000) begin @(negedge clk); t++; end
        check(done[c] == 1'b1, tag, done[c], 1);
    endtask

    task automatic idle_quiet(input string tag);
        repeat (3) begin
            @(negedge clk);
            check(!ram_re && wvalid == '0 && done == '0, tag, {ram_re, wvalid, done}, 0);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; en = '0; wready = '1;
        for (int c = 0; c < NC; c++) begin cnt[c] = 0; pend_done[c] = 0; done_prev[c] = 0; end
        repeat (3) @(negedge clk);
        check(done == '0 && wvalid == '0 && !ram_re, "R1 reset outputs", {done, wvalid, ram_re}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(done == '0 && wvalid == '0 && !ram_re, "R1 after reset", {done, wvalid, ram_re}, 0);
        mon_on = 1'b1;

        // directed: channel 0, FIFO always ready
        rdy_pct = 100; en = 2'b01;
        wait_done(0, "R2 ch0 full-rate fill");
        repeat (5) begin @(negedge clk); check(done[0], "R6 done held", done[0], 1); end
        en = 2'b00;
        @(negedge clk);
        check(!done[0], "R7 done release", done[0], 0);
        idle_quiet("R10 idle after ch0");

        // channel 1 under heavy random backpressure
        rdy_pct = 40; en = 2'b10;
        wait_done(1, "R3 ch1 backpressured fill");
        check(cnt[1] == W, "R2 ch1 word count", cnt[1], W);
        en = 2'b00;
        @(negedge clk);
        check(!done[1], "R7 ch1 release", done[1], 0);
        idle_quiet("R10 idle after ch1");

        // both requests together: lower channel first
        rdy_pct = 70; r8_watch = 1'b1; en = 2'b11;
        wait_done(0, "R8 ch0 served first");
        check(!done[1] && cnt[1] == 0, "R8 ch1 untouched", cnt[1], 0);
        repeat (3) @(negedge clk);
        en[0] = 1'b0;
        @(negedge clk);
        check(!done[0], "R7 ch0 release with ch1 pending", done[0], 0);
        wait_done(1, "R8 ch1 after ch0 handshake");
        r8_watch = 1'b0;
        en = 2'b00;
        @(negedge clk);
        check(!done[1], "R7 ch1 release", done[1], 0);
        idle_quiet("R10 idle after dual");

        // request pulse only: fill still completes, done is a single cycle
        rdy_pct = 20 + $urandom_range(60); en = 2'b01;
        @(negedge clk);
        en = 2'b00;
        wait_done(0, "R9 fill survives dropped request");
        @(negedge clk);
        check(!done[0], "R9 single-cycle done", done[0], 0);
        idle_quiet("R10 idle after pulse");

        mon_on = 1'b0;
        summary();
        $finish;
    end
endmodule